// File: doc/BRIEF.md
# Wavefront Outstanding-Operation Counters with Wait Gate

This block keeps the outstanding-operation counts for one wavefront. There are three counts. The first is for vector memory accesses. The second is shared by local-share, global-share, message and scalar memory operations. The third is for exports. When the issue stage launches an operation, it tells the block the operation kind. The block then raises every count that the operation occupies. A flat-address access goes to both the vector memory path and the shared path, so it raises both of those counts together. Each path signals completions on its own, and each completion lowers the count for that path by one.

A wait instruction gives one threshold for each count. The `ready` output is high in the same cycle in which every checked count is at or below its threshold. A threshold equal to the all-ones value of its field means that count is not checked. The vector memory path completes in issue order, so a vector memory threshold N means that every access except the newest N has finished. On the shared path the order holds only within each type of operation, and scalar memory operations complete in any order. A nonzero shared threshold is therefore unsafe while a scalar memory or flat access is still outstanding on that path. The block tracks those operations separately and raises a lint flag when a wait runs into that case. An issue that would push a count past its width is refused.

Top module: `wave_cnt_wait`

## Requirements
- R1: Reset sets all three counts to zero. The first wait after reset with all thresholds at zero reports ready.
- R2: An accepted vector memory issue (`iss_kind` 0) raises the vector count by one. A `cpl_vm` pulse lowers it by one.
- R3: An accepted flat issue (`iss_kind` 1) raises the vector count and the shared count by one each, in the same cycle.
- R4: Accepted local-share (2), global-share (3), message (4) and scalar memory (5) issues all raise the one shared count. A `cpl_lgkm` pulse lowers it by one, whatever the value of `cpl_lgkm_kind`.
- R5: An accepted export issue (`iss_kind` 6) raises the export count by one. A `cpl_exp` pulse lowers it by one.
- R6: An accepted issue and a completion in the same class in the same cycle leave a nonzero count of that class unchanged.
- R7: `iss_ok` is low when any count the presented kind would raise is at its maximum (vector 15, shared 31, export 7). A refused issue changes no count.
- R8: A threshold at its field maximum (vector 15, shared 31, export 7) disables the check on that count.
- R9: `ready` is high exactly when `wait_req` is high and every checked count is at or below its threshold, with no delay of a cycle.
- R10: `wait_hazard` is high when `wait_req` is high, the shared threshold is neither 0 nor 31, and at least one scalar memory or flat operation is outstanding on the shared path. The shared-path completion of such an operation carries `cpl_lgkm_kind` 5 or 1.
- R11: A completion that arrives while its count is zero is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An operation is being issued this cycle |
| iss_kind | input | 3 | Operation kind: 0 vmem, 1 flat, 2 lds, 3 gds, 4 msg, 5 smem, 6 export |
| iss_ok | output | 1 | The presented kind would be accepted (no count at its maximum) |
| cpl_vm | input | 1 | One vector memory completion |
| cpl_lgkm | input | 1 | One completion on the shared path |
| cpl_lgkm_kind | input | 3 | Kind of the shared-path completion, same coding as `iss_kind` |
| cpl_exp | input | 1 | One export completion |
| wait_req | input | 1 | A wait instruction is being evaluated |
| thr_vm | input | 4 | Vector count threshold; 15 means not checked |
| thr_lgkm | input | 5 | Shared count threshold; 31 means not checked |
| thr_exp | input | 3 | Export count threshold; 7 means not checked |
| ready | output | 1 | The wait is satisfied |
| wait_hazard | output | 1 | Lint: nonzero shared threshold while an unordered shared-path operation is outstanding |

## Verification
The hardest conditions to reach are the saturation edges. The export count is driven to 7 and the vector count to 15. A flat issue is then offered while only its vector half is full, and the bench confirms that the shared count does not move. The lint case needs a flat access whose shared-path completion is still outstanding while its vector half may already have finished. The stimulus retires the two halves separately and probes the wait between them. Counts are read through the wait interface only, by probing each threshold at the modelled value and at one below it.

// File: rtl/wcw_pkg.sv
package wcw_pkg;

    localparam int VM_W_DEF = 4;
    localparam int LG_W_DEF = 5;
    localparam int EX_W_DEF = 3;

    typedef enum logic [2:0] {
        OP_VMEM = 3'd0,
        OP_FLAT = 3'd1,
        OP_LDS  = 3'd2,
        OP_GDS  = 3'd3,
        OP_MSG  = 3'd4,
        OP_SMEM = 3'd5,
        OP_EXP  = 3'd6,
        OP_NONE = 3'd7
    } op_kind_e;

    // which counters an operation kind occupies
    typedef struct packed {
        logic vm;
        logic lg;
        logic ex;
        logic unord;   // completes out of order on the shared path
    } cls_hit_t;

    function automatic cls_hit_t classify(input logic [2:0] k);
        cls_hit_t h;
        h = '0;
        case (op_kind_e'(k))
            OP_VMEM: h.vm = 1'b1;
            OP_FLAT: begin h.vm = 1'b1; h.lg = 1'b1; h.unord = 1'b1; end
            OP_LDS,
            OP_GDS,
            OP_MSG:  h.lg = 1'b1;
            OP_SMEM: begin h.lg = 1'b1; h.unord = 1'b1; end
            OP_EXP:  h.ex = 1'b1;
            default: h = '0;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/wcw_counter.sv
module wcw_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         full
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic up, down;

    // a decrement at zero is dropped; an increment at full is dropped
    assign down = dec && (cnt != '0);
    assign up   = inc && (cnt != MAXV);
    assign full = (cnt == MAXV);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (up && !down) begin
            cnt <= cnt + 1'b1;
        end else if (down && !up) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/wcw_issue_gate.sv
module wcw_issue_gate
    import wcw_pkg::*;
(
    input  logic       iss_valid,
    input  logic [2:0] iss_kind,
    input  logic       vm_full,
    input  logic       lg_full,
    input  logic       ex_full,
    input  logic       un_full,
    output logic       iss_ok,
    output cls_hit_t   inc
);
    cls_hit_t need;

    always_comb begin
        need   = classify(iss_kind);
        iss_ok = !((need.vm && vm_full) ||
                   (need.lg && lg_full) ||
                   (need.ex && ex_full) ||
                   (need.unord && un_full));
        inc    = (iss_valid && iss_ok) ? need : '0;
    end
endmodule

// File: rtl/wcw_wait_eval.sv
module wcw_wait_eval #(
    parameter int VM_W = 4,
    parameter int LG_W = 5,
    parameter int EX_W = 3
) (
    input  logic            wait_req,
    input  logic [VM_W-1:0] cnt_vm,
    input  logic [LG_W-1:0] cnt_lg,
    input  logic [EX_W-1:0] cnt_ex,
    input  logic            unord_pending,
    input  logic [VM_W-1:0] thr_vm,
    input  logic [LG_W-1:0] thr_lgkm,
    input  logic [EX_W-1:0] thr_exp,
    output logic            ready,
    output logic            wait_hazard
);
    logic skip_vm, skip_lg, skip_ex;
    logic ok_vm, ok_lg, ok_ex;

    always_comb begin
        skip_vm = &thr_vm;
        skip_lg = &thr_lgkm;
        skip_ex = &thr_exp;
        ok_vm   = skip_vm || (cnt_vm <= thr_vm);
        ok_lg   = skip_lg || (cnt_lg <= thr_lgkm);
        ok_ex   = skip_ex || (cnt_ex <= thr_exp);
        ready   = wait_req && ok_vm && ok_lg && ok_ex;
        // an out-of-order shared-path op makes only a zero threshold safe
        wait_hazard = wait_req && (thr_lgkm != '0) && !skip_lg && unord_pending;
    end
endmodule

// File: rtl/wave_cnt_wait.sv
module wave_cnt_wait
    import wcw_pkg::*;
#(
    parameter int VM_W = VM_W_DEF,
    parameter int LG_W = LG_W_DEF,
    parameter int EX_W = EX_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            iss_valid,
    input  logic [2:0]      iss_kind,
    output logic            iss_ok,
    input  logic            cpl_vm,
    input  logic            cpl_lgkm,
    input  logic [2:0]      cpl_lgkm_kind,
    input  logic            cpl_exp,
    input  logic            wait_req,
    input  logic [VM_W-1:0] thr_vm,
    input  logic [LG_W-1:0] thr_lgkm,
    input  logic [EX_W-1:0] thr_exp,
    output logic            ready,
    output logic            wait_hazard
);
    logic [VM_W-1:0] cnt_vm;
    logic [LG_W-1:0] cnt_lg;
    logic [EX_W-1:0] cnt_ex;
    logic [LG_W-1:0] cnt_un;
    logic            vm_full, lg_full, ex_full, un_full;
    cls_hit_t        inc;
    cls_hit_t        cpl_cls;
    logic            un_dec;

    always_comb begin
        cpl_cls = classify(cpl_lgkm_kind);
        un_dec  = cpl_lgkm && cpl_cls.unord;
    end

    wcw_issue_gate u_gate (
        .iss_valid (iss_valid),
        .iss_kind  (iss_kind),
        .vm_full   (vm_full),
        .lg_full   (lg_full),
        .ex_full   (ex_full),
        .un_full   (un_full),
        .iss_ok    (iss_ok),
        .inc       (inc)
    );

    wcw_counter #(.W(VM_W)) u_vm (
        .clk (clk), .rst (rst), .inc (inc.vm), .dec (cpl_vm),
        .cnt (cnt_vm), .full (vm_full)
    );

    wcw_counter #(.W(LG_W)) u_lg (
        .clk (clk), .rst (rst), .inc (inc.lg), .dec (cpl_lgkm),
        .cnt (cnt_lg), .full (lg_full)
    );

    wcw_counter #(.W(EX_W)) u_ex (
        .clk (clk), .rst (rst), .inc (inc.ex), .dec (cpl_exp),
        .cnt (cnt_ex), .full (ex_full)
    );

    // shadow count of shared-path operations that may retire out of order
    wcw_counter #(.W(LG_W)) u_un (
        .clk (clk), .rst (rst), .inc (inc.unord), .dec (un_dec),
        .cnt (cnt_un), .full (un_full)
    );

    wcw_wait_eval #(.VM_W(VM_W), .LG_W(LG_W), .EX_W(EX_W)) u_eval (
        .wait_req      (wait_req),
        .cnt_vm        (cnt_vm),
        .cnt_lg        (cnt_lg),
        .cnt_ex        (cnt_ex),
        .unord_pending (cnt_un != '0),
        .thr_vm        (thr_vm),
        .thr_lgkm      (thr_lgkm),
        .thr_exp       (thr_exp),
        .ready         (ready),
        .wait_hazard   (wait_hazard)
    );
endmodule

// File: rtl/wave_cnt_wait_chk.sv
module wave_cnt_wait_chk
    import wcw_pkg::*;
#(
    parameter int VM_W = 4,
    parameter int LG_W = 5,
    parameter int EX_W = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            iss_valid,
    input logic [2:0]      iss_kind,
    input logic            iss_ok,
    input logic            cpl_vm,
    input logic            cpl_lgkm,
    input logic            cpl_exp,
    input logic            wait_req,
    input logic            ready,
    input logic            wait_hazard,
    input logic [VM_W-1:0] cnt_vm,
    input logic [LG_W-1:0] cnt_lg,
    input logic [EX_W-1:0] cnt_ex
);
    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (cnt_vm == '0 && cnt_lg == '0 && cnt_ex == '0));

    // R9
    ready_needs_wait_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> wait_req);

    // R10
    hazard_needs_wait_chk: assert property (@(posedge clk) disable iff (rst)
        wait_hazard |-> wait_req);

    // R3
    flat_both_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_ok && iss_kind == OP_FLAT && !cpl_vm && !cpl_lgkm)
        |=> (cnt_vm == $past(cnt_vm) + 1'b1 && cnt_lg == $past(cnt_lg) + 1'b1));

    // R6
    same_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_ok && iss_kind == OP_EXP && cpl_exp && cnt_ex != '0)
        |=> $stable(cnt_ex));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (&cnt_vm) |=> (cnt_vm != '0));

    // R7
    full_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_kind == OP_EXP && (&cnt_ex)) |-> !iss_ok);

    // R11
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_ex == '0) |=> (cnt_ex <= EX_W'(1)));
endmodule

bind wave_cnt_wait wave_cnt_wait_chk #(.VM_W(VM_W), .LG_W(LG_W), .EX_W(EX_W)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .iss_valid   (iss_valid),
    .iss_kind    (iss_kind),
    .iss_ok      (iss_ok),
    .cpl_vm      (cpl_vm),
    .cpl_lgkm    (cpl_lgkm),
    .cpl_exp     (cpl_exp),
    .wait_req    (wait_req),
    .ready       (ready),
    .wait_hazard (wait_hazard),
    .cnt_vm      (cnt_vm),
    .cnt_lg      (cnt_lg),
    .cnt_ex      (cnt_ex)
);

// File: tb/test_wave_cnt_wait.sv
module test_wave_cnt_wait;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       iss_valid = 1'b0;
    logic [2:0] iss_kind = 3'd7;
    logic       iss_ok;
    logic       cpl_vm = 1'b0;
    logic       cpl_lgkm = 1'b0;
    logic [2:0] cpl_lgkm_kind = 3'd2;
    logic       cpl_exp = 1'b0;
    logic       wait_req = 1'b0;
    logic [3:0] thr_vm = 4'd15;
    logic [4:0] thr_lgkm = 5'd31;
    logic [2:0] thr_exp = 3'd7;
    logic       ready;
    logic       wait_hazard;

    always #2 clk = ~clk;   // 250 MHz

    wave_cnt_wait i_wave_cnt_wait (
        .clk (clk), .rst (rst),
        .iss_valid (iss_valid), .iss_kind (iss_kind), .iss_ok (iss_ok),
        .cpl_vm (cpl_vm), .cpl_lgkm (cpl_lgkm), .cpl_lgkm_kind (cpl_lgkm_kind),
        .cpl_exp (cpl_exp), .wait_req (wait_req),
        .thr_vm (thr_vm), .thr_lgkm (thr_lgkm), .thr_exp (thr_exp),
        .ready (ready), .wait_hazard (wait_hazard)
    );

    typedef struct {
        string tag;
        bit    is_issue;
        bit    rdy;
        bit    haz;
        bit    ok;
    } exp_item_t;

    exp_item_t sb_q[$];
    event      sample_ev;
    int        checks = 0;
    int        errors = 0;
    bit        done = 1'b0;

    // model counts
    int mvm = 0, mlg = 0, mex = 0, mun = 0;

    // monitor: compares design outputs with queued expectations
    initial begin
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                checks++;
                if (it.is_issue) begin
                    if (iss_ok !== it.ok) begin
                        errors++;
                        $display("FAIL %s iss_ok actual=%b expected=%b", it.tag, iss_ok, it.ok);
                    end
                end else if (ready !== it.rdy || wait_hazard !== it.haz) begin
                    errors++;
                    $display("FAIL %s ready/hazard actual=%b/%b expected=%b/%b",
                             it.tag, ready, wait_hazard, it.rdy, it.haz);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    function automatic bit needs(input int k, input int which);
        case (which)
            0: return (k == 0 || k == 1);
            1: return (k >= 1 && k <= 5);
            2: return (k == 6);
            default: return (k == 1 || k == 5);
        endcase
    endfunction

    // one clock of issue and completion activity
    task automatic step(input string tag, input bit iv, input int kind,
                        input bit cv, input bit cl, input int lkind, input bit ce);
        bit ok;
        bit acc;
        exp_item_t it;
        @(negedge clk);
        iss_valid = iv; iss_kind = 3'(kind);
        cpl_vm = cv; cpl_lgkm = cl; cpl_lgkm_kind = 3'(lkind); cpl_exp = ce;
        ok = !((needs(kind, 0) && mvm == 15) || (needs(kind, 1) && mlg == 31) ||
               (needs(kind, 2) && mex == 7) || (needs(kind, 3) && mun == 31));
        #1;
        if (iv) begin
            it.tag = tag; it.is_issue = 1'b1; it.rdy = 1'b0; it.haz = 1'b0; it.ok = ok;
            sb_q.push_back(it);
            ->sample_ev;
        end
        acc = iv && ok;
        @(posedge clk);
        begin
            bit vi, vd, li, ld, ei, ed, ui, ud;
            vi = acc && needs(kind, 0); vd = cv && mvm > 0;
            li = acc && needs(kind, 1); ld = cl && mlg > 0;
            ei = acc && needs(kind, 2); ed = ce && mex > 0;
            ui = acc && needs(kind, 3); ud = cl && (lkind == 5 || lkind == 1) && mun > 0;
            mvm += int'(vi) - int'(vd);
            mlg += int'(li) - int'(ld);
            mex += int'(ei) - int'(ed);
            mun += int'(ui) - int'(ud);
        end
        #1;
        iss_valid = 1'b0; iss_kind = 3'd7;
        cpl_vm = 1'b0; cpl_lgkm = 1'b0; cpl_exp = 1'b0;
    endtask

    task automatic probe(input string tag, input bit wr, input int tv, input int tl, input int te);
        exp_item_t it;
        @(negedge clk);
        wait_req = wr; thr_vm = 4'(tv); thr_lgkm = 5'(tl); thr_exp = 3'(te);
        #1;
        it.tag = tag; it.is_issue = 1'b0; it.ok = 1'b0;
        it.rdy = wr && (tv == 15 || mvm <= tv) && (tl == 31 || mlg <= tl) && (te == 7 || mex <= te);
        it.haz = wr && tl != 0 && tl != 31 && mun != 0;
        sb_q.push_back(it);
        ->sample_ev;
        #1;
        wait_req = 1'b0;
    endtask

    // reads each count through the wait: ready at the count, not one below
    task automatic check_counts(input string tag);
        probe(tag, 1'b1, mvm, 31, 7);
        if (mvm > 0) probe(tag, 1'b1, mvm - 1, 31, 7);
        probe(tag, 1'b1, 15, mlg, 7);
        if (mlg > 0) probe(tag, 1'b1, 15, mlg - 1, 7);
        probe(tag, 1'b1, 15, 31, mex);
        if (mex > 0) probe(tag, 1'b1, 15, 31, mex - 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: counts cleared by reset
        check_counts("R1 reset counts");
        probe("R1 all-zero wait", 1'b1, 0, 0, 0);
        // R9: no wait request, no ready
        probe("R9 ready without wait", 1'b0, 15, 31, 7);

        // R2: vector memory issue and completion
        for (int i = 0; i < 3; i++) step("R2 vmem issue", 1, 0, 0, 0, 2, 0);
        check_counts("R2 vm after three");
        step("R2 vmem complete", 0, 7, 1, 0, 2, 0);
        check_counts("R2 vm after completion");

        // R3: flat raises both; R10: lint while its shared half is open
        step("R3 flat issue", 1, 1, 0, 0, 2, 0);
        check_counts("R3 flat both counts");
        probe("R10 hazard with nonzero thr", 1'b1, 15, 1, 7);
        probe("R10 no hazard with zero thr", 1'b1, 15, 0, 7);
        probe("R10 no hazard when unchecked", 1'b1, 15, 31, 7);
        step("R10 vm half retires", 0, 7, 1, 0, 2, 0);
        probe("R10 hazard after vm half only", 1'b1, 15, 2, 7);
        step("R10 shared half retires", 0, 7, 0, 1, 1, 0);
        probe("R10 hazard cleared", 1'b1, 15, 2, 7);
        check_counts("R3 after flat retired");

        // R4: every shared-path kind uses one count
        step("R4 lds", 1, 2, 0, 0, 2, 0);
        step("R4 gds", 1, 3, 0, 0, 2, 0);
        step("R4 msg", 1, 4, 0, 0, 2, 0);
        step("R4 smem", 1, 5, 0, 0, 2, 0);
        check_counts("R4 shared count");
        step("R4 lds complete", 0, 7, 0, 1, 2, 0);
        probe("R10 smem still open", 1'b1, 15, 3, 7);
        step("R4 smem complete", 0, 7, 0, 1, 5, 0);
        probe("R10 smem retired", 1'b1, 15, 3, 7);
        check_counts("R4 shared after completions");

        // R5: exports
        step("R5 export", 1, 6, 0, 0, 2, 0);
        step("R5 export", 1, 6, 0, 0, 2, 0);
        check_counts("R5 export count");

        // R6: same-cycle issue and completion
        step("R6 vm issue+complete", 1, 0, 1, 0, 2, 0);
        step("R6 exp issue+complete", 1, 6, 0, 0, 2, 1);
        check_counts("R6 counts unchanged");

        // R7: saturation and refusal
        for (int i = 0; i < 5; i++) step("R7 fill export", 1, 6, 0, 0, 2, 0);
        step("R7 export refused", 1, 6, 0, 0, 2, 0);
        check_counts("R7 export held at max");
        while (mvm < 15) step("R7 fill vm", 1, 0, 0, 0, 2, 0);
        step("R7 flat refused on vm full", 1, 1, 0, 0, 2, 0);
        step("R7 lds accepted", 1, 2, 0, 0, 2, 0);
        check_counts("R7 counts after refusals");

        // R8: unchecked thresholds with full counts
        probe("R8 all unchecked", 1'b1, 15, 31, 7);
        probe("R8 vm checked at 14", 1'b1, 14, 31, 7);
        probe("R8 exp checked at 6", 1'b1, 15, 31, 6);

        // R11: completions at zero are dropped
        for (int i = 0; i < 9; i++) step("R11 drain export", 0, 7, 0, 0, 2, 1);
        check_counts("R11 export drained");
        step("R11 export after drain", 1, 6, 0, 0, 2, 0);
        check_counts("R11 export one");
        probe("R9 ready all met", 1'b1, 15, mlg, 1);

        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule